// File: doc/BRIEF.md
# Single-Bus Microcoded Datapath Controller

This block is a 32-bit processing core in which every register transfer travels over one shared data bus. A small microcode sequencer walks a case-decoded control store one microinstruction per cycle. Each microinstruction raises at most one bus source (register file, immediate extender, ALU or memory) and any mix of load strobes. The load strobes capture the bus into the instruction register, the two ALU operand latches or the memory address register. A register-file write strobe stores the bus into the register chosen by a select field. The PC sits in the register file as index 32.

The core fetches an instruction, dispatches on its opcode, runs a short microroutine and returns to fetch. Memory sits outside the core behind a word-wide port. The port has an address taken from the memory address register, write data taken from the B latch, read and write strobes, and a busy input. While busy is high, the microinstruction that touches memory is held.

Top module: `sbmc_core`

## Requirements
- R1: While reset is high, mem_rd, mem_wr and mem_addr are all 0, and the first fetch after reset reads from address 0.
- R2: No more than one of the four bus sources drives the bus in any cycle.
- R3: Fetch takes three microinstructions: MA and A take the PC, IR takes memory, and the PC becomes A+4. With no busy cycles, an immediate add followed by a store writes memory in cycle 11 after reset release. Each busy cycle delays that write by one cycle.
- R4: Opcode 0 (bits 31:26) reads rs (bits 25:21) and rt (bits 20:16) and writes rd (bits 15:11). The result depends on funct (bits 5:0): 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, any other value add. Arithmetic wraps modulo 2^32.
- R5: Opcode 0x08 writes rt = rs + sign-extended imm (bits 15:0). Opcode 0x0C writes rt = rs + zero-extended imm.
- R6: Opcode 0x0F writes rt = imm shifted left by 16, with the low half zero.
- R7: Opcode 0x2B writes Reg[rt] to memory at byte address Reg[rs]; no offset is added.
- R8: Opcode 0x04 branches when Reg[rs] equals Reg[rt], using the ALU zero flag. The new PC is (address of branch + 4) + sign-extended imm times 4. When the registers differ, execution falls through to the next instruction.
- R9: Register 0 always reads as 0, and writes to it are dropped.
- R10: While mem_busy is high during a memory microinstruction, no latch, register or microprogram counter changes. The access completes exactly once, in the first cycle busy is low.
- R11: An opcode not listed above changes no register and returns straight to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 32 | Read data for the word at mem_addr |
| mem_busy | input | 1 | Memory not ready; holds the current microinstruction |
| mem_addr | output | 32 | Byte address, from the memory address register |
| mem_wdata | output | 32 | Write data, from the B latch |
| mem_rd | output | 1 | Current microinstruction reads memory onto the bus |
| mem_wr | output | 1 | Current microinstruction writes memory |

## Verification
Assertions check four things on every cycle: bus exclusivity, the freeze of all datapath state during a busy hold, the PC step at the end of every fetch, and that the instruction register captures the memory word. Only the bench's programs can show the rest. That covers instruction semantics and immediate-extension modes, branch direction and target, the zero register, the behaviour of undefined opcodes, and the exact cycle count of a fetch–execute sequence under different memory latencies. All of it is observed through the words the core stores to memory.

// File: rtl/sbmc_pkg.sv
package sbmc_pkg;

  localparam int UPC_W = 5;

  typedef enum logic [2:0] {RS_RS, RS_RT, RS_RD, RS_PC, RS_LINK} rsel_e;
  typedef enum logic [1:0] {EXT_ZERO, EXT_SIGN, EXT_SIGN_SH2, EXT_UPPER} ext_e;
  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_INC4, OP_FUNCT} aop_e;
  typedef enum logic [1:0] {SQ_NEXT, SQ_DISPATCH, SQ_FETCH, SQ_BRZ} seq_e;

  // 17 control signals plus a 2-bit sequencing code
  typedef struct packed {
    logic  ld_ir;
    logic  ld_a;
    logic  ld_b;
    logic  ld_ma;
    rsel_e rsel;
    logic  reg_wr;
    logic  en_reg;
    ext_e  ext;
    logic  en_imm;
    logic  en_alu;
    aop_e  aop;
    logic  mem_wr;
    logic  en_mem;
    seq_e  seq;
  } uinst_t;

  // opcodes
  localparam logic [5:0] OPC_RR   = 6'h00;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_ADDZ = 6'h0C;
  localparam logic [5:0] OPC_LUI  = 6'h0F;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  // control store entry points
  localparam logic [UPC_W-1:0] U_F0  = 5'd0;
  localparam logic [UPC_W-1:0] U_F1  = 5'd1;
  localparam logic [UPC_W-1:0] U_F2  = 5'd2;
  localparam logic [UPC_W-1:0] U_RR  = 5'd3;
  localparam logic [UPC_W-1:0] U_AI  = 5'd6;
  localparam logic [UPC_W-1:0] U_AZ  = 5'd9;
  localparam logic [UPC_W-1:0] U_LU  = 5'd12;
  localparam logic [UPC_W-1:0] U_SW  = 5'd13;
  localparam logic [UPC_W-1:0] U_BQ  = 5'd16;

endpackage

// File: rtl/sbmc_useq.sv
module sbmc_useq
  import sbmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       opcode,
  input  logic             zero,
  input  logic             busy,
  output uinst_t           uop,
  output logic             stall,
  output logic [UPC_W-1:0] upc
);

  logic [UPC_W-1:0] upc_q, upc_d, disp;

  // control store, decoded from the registered microprogram counter
  always_comb begin
    uop = '0;
    unique case (upc_q)
      5'd0:  begin uop.rsel = RS_PC; uop.en_reg = 1'b1; uop.ld_ma = 1'b1; uop.ld_a = 1'b1; end
      5'd1:  begin uop.en_mem = 1'b1; uop.ld_ir = 1'b1; end
      5'd2:  begin uop.en_alu = 1'b1; uop.aop = OP_INC4; uop.rsel = RS_PC; uop.reg_wr = 1'b1;
                   uop.seq = SQ_DISPATCH; end
      // register-register
      5'd3:  begin uop.rsel = RS_RS; uop.en_reg = 1'b1; uop.ld_a = 1'b1; end
      5'd4:  begin uop.rsel = RS_RT; uop.en_reg = 1'b1; uop.ld_b = 1'b1; end
      5'd5:  begin uop.en_alu = 1'b1; uop.aop = OP_FUNCT; uop.rsel = RS_RD; uop.reg_wr = 1'b1;
                   uop.seq = SQ_FETCH; end
      // add sign-extended immediate
      5'd6:  begin uop.rsel = RS_RS; uop.en_reg = 1'b1; uop.ld_a = 1'b1; end
      5'd7:  begin uop.ext = EXT_SIGN; uop.en_imm = 1'b1; uop.ld_b = 1'b1; end
      5'd8:  begin uop.en_alu = 1'b1; uop.aop = OP_ADD; uop.rsel = RS_RT; uop.reg_wr = 1'b1;
                   uop.seq = SQ_FETCH; end
      // add zero-extended immediate
      5'd9:  begin uop.ext = EXT_ZERO; uop.en_imm = 1'b1; uop.ld_b = 1'b1; end
      5'd10: begin uop.rsel = RS_RS; uop.en_reg = 1'b1; uop.ld_a = 1'b1; end
      5'd11: begin uop.en_alu = 1'b1; uop.aop = OP_ADD; uop.rsel = RS_RT; uop.reg_wr = 1'b1;
                   uop.seq = SQ_FETCH; end
      // load upper
      5'd12: begin uop.ext = EXT_UPPER; uop.en_imm = 1'b1; uop.rsel = RS_RT; uop.reg_wr = 1'b1;
                   uop.seq = SQ_FETCH; end
      // store word
      5'd13: begin uop.rsel = RS_RS; uop.en_reg = 1'b1; uop.ld_ma = 1'b1; end
      5'd14: begin uop.rsel = RS_RT; uop.en_reg = 1'b1; uop.ld_b = 1'b1; end
      5'd15: begin uop.mem_wr = 1'b1; uop.seq = SQ_FETCH; end
      // branch on equal
      5'd16: begin uop.rsel = RS_RS; uop.en_reg = 1'b1; uop.ld_a = 1'b1; end
      5'd17: begin uop.rsel = RS_RT; uop.en_reg = 1'b1; uop.ld_b = 1'b1; end
      5'd18: begin uop.aop = OP_SUB; uop.seq = SQ_BRZ; end
      5'd19: begin uop.rsel = RS_PC; uop.en_reg = 1'b1; uop.ld_a = 1'b1; end
      5'd20: begin uop.ext = EXT_SIGN_SH2; uop.en_imm = 1'b1; uop.ld_b = 1'b1; end
      5'd21: begin uop.en_alu = 1'b1; uop.aop = OP_ADD; uop.rsel = RS_PC; uop.reg_wr = 1'b1;
                   uop.seq = SQ_FETCH; end
      default: uop.seq = SQ_FETCH;
    endcase
  end

  always_comb begin
    unique case (opcode)
      OPC_RR:   disp = U_RR;
      OPC_ADDI: disp = U_AI;
      OPC_ADDZ: disp = U_AZ;
      OPC_LUI:  disp = U_LU;
      OPC_SW:   disp = U_SW;
      OPC_BEQ:  disp = U_BQ;
      default:  disp = U_F0;
    endcase
  end

  assign stall = busy & (uop.en_mem | uop.mem_wr);

  always_comb begin
    if (stall) upc_d = upc_q;
    else begin
      unique case (uop.seq)
        SQ_NEXT:     upc_d = upc_q + UPC_W'(1);
        SQ_DISPATCH: upc_d = disp;
        SQ_BRZ:      upc_d = zero ? upc_q + UPC_W'(1) : U_F0;
        default:     upc_d = U_F0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) upc_q <= U_F0;
    else     upc_q <= upc_d;
  end

  assign upc = upc_q;

endmodule

// File: rtl/sbmc_regfile.sv
module sbmc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  localparam int IDX_W = $clog2(NREG) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  output logic [XLEN-1:0]  pc
);

  logic [XLEN-1:0] gpr [NREG];
  logic [XLEN-1:0] pc_q;

  // general registers: plain array, no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx < IDX_W'(NREG)) && (wr_idx != '0))
      gpr[wr_idx[IDX_W-2:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else if (wr_en && (wr_idx == IDX_W'(NREG))) pc_q <= wr_data;
  end

  always_comb begin
    if (rd_idx == IDX_W'(NREG)) rd_data = pc_q;
    else if (rd_idx == '0)      rd_data = '0;
    else                        rd_data = gpr[rd_idx[IDX_W-2:0]];
  end

  assign pc = pc_q;

endmodule

// File: rtl/sbmc_alu.sv
module sbmc_alu
  import sbmc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  aop_e            aop,
  input  logic [5:0]      funct,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    unique case (aop)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_INC4: y = a + XLEN'(4);
      default: begin
        unique case (funct)
          FN_SUB:  y = a - b;
          FN_AND:  y = a & b;
          FN_OR:   y = a | b;
          default: y = a + b;
        endcase
      end
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sbmc_core.sv
module sbmc_core
  import sbmc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_busy,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr
);

  localparam int IDX_W = $clog2(NREG) + 1;
  localparam int IMM_W = 16;

  logic [XLEN-1:0] ir_q, a_q, b_q, ma_q;
  logic [XLEN-1:0] bus, imm_ext, alu_y, rf_rdata, pc;
  logic [IDX_W-1:0] rf_idx;
  logic            alu_zero, stall;
  logic [UPC_W-1:0] upc;
  uinst_t          uop;

  logic [5:0]       opcode;
  logic [4:0]       f_rs, f_rt, f_rd;
  logic [IMM_W-1:0] imm;

  assign opcode = ir_q[31:26];
  assign f_rs   = ir_q[25:21];
  assign f_rt   = ir_q[20:16];
  assign f_rd   = ir_q[15:11];
  assign imm    = ir_q[IMM_W-1:0];

  sbmc_useq u_seq (
    .clk(clk), .rst(rst), .opcode(opcode), .zero(alu_zero), .busy(mem_busy),
    .uop(uop), .stall(stall), .upc(upc)
  );

  always_comb begin
    unique case (uop.rsel)
      RS_RS:   rf_idx = IDX_W'(f_rs);
      RS_RT:   rf_idx = IDX_W'(f_rt);
      RS_RD:   rf_idx = IDX_W'(f_rd);
      RS_PC:   rf_idx = IDX_W'(NREG);
      RS_LINK: rf_idx = IDX_W'(NREG - 1);
      default: rf_idx = '0;
    endcase
  end

  sbmc_regfile #(.XLEN(XLEN), .NREG(NREG), .RESET_PC(RESET_PC)) u_rf (
    .clk(clk), .rst(rst), .rd_idx(rf_idx), .rd_data(rf_rdata),
    .wr_en(uop.reg_wr & ~stall), .wr_idx(rf_idx), .wr_data(bus), .pc(pc)
  );

  sbmc_alu #(.XLEN(XLEN)) u_alu (
    .a(a_q), .b(b_q), .aop(uop.aop), .funct(ir_q[5:0]), .y(alu_y), .zero(alu_zero)
  );

  always_comb begin
    unique case (uop.ext)
      EXT_ZERO:     imm_ext = XLEN'(imm);
      EXT_SIGN:     imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
      EXT_SIGN_SH2: imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} << 2;
      default:      imm_ext = XLEN'(imm) << IMM_W;
    endcase
  end

  // shared bus: AND-OR of the enabled source
  always_comb begin
    bus = '0;
    if (uop.en_reg) bus |= rf_rdata;
    if (uop.en_imm) bus |= imm_ext;
    if (uop.en_alu) bus |= alu_y;
    if (uop.en_mem) bus |= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= RESET_PC;
    end else if (!stall) begin
      if (uop.ld_ir) ir_q <= bus;
      if (uop.ld_a)  a_q  <= bus;
      if (uop.ld_b)  b_q  <= bus;
      if (uop.ld_ma) ma_q <= bus;
    end
  end

  assign mem_addr  = ma_q;
  assign mem_wdata = b_q;
  assign mem_rd    = uop.en_mem;
  assign mem_wr    = uop.mem_wr;

  // R2: bus contention
  a_r2_one_driver: assert property (@(posedge clk) disable iff (rst)
    $countones({uop.en_reg, uop.en_imm, uop.en_alu, uop.en_mem}) <= 1)
    else $error("bus contention");

  // R10: nothing moves while memory is busy
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(ir_q) && $stable(a_q) && $stable(b_q) && $stable(ma_q)
               && $stable(pc) && $stable(upc)));

  // R3: every fetch advances the PC by one word
  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    (upc == U_F2) |=> (pc == $past(pc) + XLEN'(4)));

  // R3: instruction register takes the memory word
  a_r3_ir_load: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && uop.ld_ir && !mem_busy) |=> (ir_q == $past(mem_rdata)));

  // R7: read and write never share a cycle
  a_r7_rw_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

// File: tb/sbmc_core_tb.sv
module sbmc_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic mem_busy, mem_rd, mem_wr;

  int errors = 0;
  int checks = 0;

  logic [31:0] mem [0:1023];
  int lat = 0;
  int wcnt;
  int cyc;
  int wr_count;
  int first_wr;
  logic [31:0] prog[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbmc_core u_dut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_busy(mem_busy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  // memory model with a programmable wait count per access
  assign mem_rdata = mem[mem_addr[11:2]];
  assign mem_busy  = (mem_rd || mem_wr) && (wcnt < lat);

  always @(posedge clk) begin
    if (rst) begin
      wcnt <= 0; cyc <= 0; wr_count <= 0; first_wr <= -1;
    end else begin
      cyc <= cyc + 1;
      if (mem_rd || mem_wr) wcnt <= mem_busy ? wcnt + 1 : 0;
      if (mem_wr && !mem_busy) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_count <= wr_count + 1;
        if (first_wr < 0) first_wr <= cyc;
      end
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // store register src to byte 0x400, then spin on a self-branch
  task automatic add_store_tail(int src);
    prog.push_back(enc_i(6'h0C, 0, 4, 16'h0400));
    prog.push_back(enc_i(6'h2B, 4, src, 16'h0000));
    prog.push_back(enc_i(6'h04, 0, 0, 16'hFFFF));
  endtask

  task automatic run(int latency, int ncyc);
    @(negedge clk);
    rst = 1'b1;
    lat = latency;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    foreach (prog[i]) mem[i] = prog[i];
    mem[256] = SENT;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (ncyc) @(negedge clk);
  endtask

  localparam logic [101:0] VEC [8] = '{
    {6'h20, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    {6'h20, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {6'h22, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
    {6'h22, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF},
    {6'h24, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200},
    {6'h25, 32'h1200_0000, 32'h0000_0034, 32'h1200_0034},
    {6'h21, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030},
    {6'h22, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000}
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 mem_rd in reset", {31'h0, mem_rd}, 32'h0);
    check("R1 mem_wr in reset", {31'h0, mem_wr}, 32'h0);
    check("R1 mem_addr in reset", mem_addr, 32'h0);

    // R4: vector table, latency varies per entry
    for (int v = 0; v < 8; v++) begin
      logic [31:0] va, vb;
      va = VEC[v][95:64];
      vb = VEC[v][63:32];
      prog.delete();
      prog.push_back(enc_i(6'h0F, 0, 1, va[31:16]));
      prog.push_back(enc_i(6'h0C, 1, 1, va[15:0]));
      prog.push_back(enc_i(6'h0F, 0, 2, vb[31:16]));
      prog.push_back(enc_i(6'h0C, 2, 2, vb[15:0]));
      prog.push_back(enc_r(1, 2, 3, VEC[v][101:96]));
      add_store_tail(3);
      run(v % 4, 300);
      check($sformatf("R4 vector %0d", v), mem[256], VEC[v][31:0]);
    end

    // R1, R3, R9: first fetch at 0, exact timing, zero register
    prog.delete();
    add_store_tail(0);
    run(0, 60);
    check("R3 write cycle, no wait", first_wr, 32'd11);
    check("R9 r0 stored as zero", mem[256], 32'h0);
    run(2, 80);
    check("R3 write cycle, two waits", first_wr, 32'd17);

    // R9: write to r0 is dropped
    prog.delete();
    prog.push_back(enc_i(6'h0C, 0, 0, 16'h0005));
    add_store_tail(0);
    run(1, 100);
    check("R9 r0 after write", mem[256], 32'h0);

    // R5: sign and zero extension
    prog.delete();
    prog.push_back(enc_i(6'h08, 0, 5, 16'hFFFF));
    add_store_tail(5);
    run(0, 80);
    check("R5 addi sign", mem[256], 32'hFFFF_FFFF);
    prog.delete();
    prog.push_back(enc_i(6'h0C, 0, 6, 16'hFFFF));
    add_store_tail(6);
    run(0, 80);
    check("R5 addz zero", mem[256], 32'h0000_FFFF);
    prog.delete();
    prog.push_back(enc_i(6'h0C, 0, 1, 16'h000A));
    prog.push_back(enc_i(6'h08, 1, 1, 16'hFFFE));
    add_store_tail(1);
    run(1, 120);
    check("R5 addi negative", mem[256], 32'h0000_0008);

    // R6: load upper
    prog.delete();
    prog.push_back(enc_i(6'h0C, 0, 7, 16'h1234));
    prog.push_back(enc_i(6'h0F, 0, 7, 16'h8001));
    add_store_tail(7);
    run(0, 100);
    check("R6 lui", mem[256], 32'h8001_0000);

    // R7: store to a second address
    prog.delete();
    prog.push_back(enc_i(6'h0C, 0, 9, 16'h0408));
    prog.push_back(enc_i(6'h0C, 0, 3, 16'h00AB));
    prog.push_back(enc_i(6'h2B, 9, 3, 16'h0000));
    prog.push_back(enc_i(6'h04, 0, 0, 16'hFFFF));
    run(0, 100);
    check("R7 store at 0x408", mem[258], 32'h0000_00AB);
    check("R7 sentinel untouched", mem[256], SENT);

    // R8: taken and not taken
    for (int t = 0; t < 2; t++) begin
      prog.delete();
      prog.push_back(enc_i(6'h0C, 0, 1, 16'h0005));
      prog.push_back(enc_i(6'h0C, 0, 2, (t == 0) ? 16'h0005 : 16'h0006));
      prog.push_back(enc_i(6'h0C, 0, 3, 16'h0007));
      prog.push_back(enc_i(6'h04, 1, 2, 16'h0001));
      prog.push_back(enc_i(6'h0C, 0, 3, 16'h0001));
      add_store_tail(3);
      run(t, 200);
      check(t == 0 ? "R8 branch taken" : "R8 branch not taken",
            mem[256], (t == 0) ? 32'h7 : 32'h1);
    end

    // R10: long waits, single write
    prog.delete();
    prog.push_back(enc_i(6'h0C, 0, 3, 16'h0042));
    add_store_tail(3);
    run(3, 150);
    check("R10 data under waits", mem[256], 32'h0000_0042);
    check("R10 single write", wr_count, 32'd1);

    // R11: unknown opcode
    prog.delete();
    prog.push_back(enc_i(6'h0C, 0, 3, 16'h0009));
    prog.push_back(enc_i(6'h3F, 0, 3, 16'h0055));
    add_store_tail(3);
    run(0, 120);
    check("R11 unknown opcode", mem[256], 32'h0000_0009);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule